// File: doc/BRIEF.md
# Frequency Acquisition Sweep Sequencer

This block drives a clock recovery loop toward lock by walking a signed frequency-control code across a fixed window around the centre frequency. Zero stands for the centre. The end codes `+LIMIT` and `-LIMIT` stand for +10% and -10% of the centre. The block moves only on a slow system tick, which is a one-cycle enable that has no relation to the data rate. On each tick it takes one step of `STEP` codes. A sweep cycle climbs from the bottom of the window to the top, falls back to the bottom, and then spends one extra tick settling before it starts again. Cycles repeat without limit until lock is reported.

Two inputs, a phase-lock indication and a data-present flag, come from another timing domain. Each passes through a short synchronizer before it is used. While lock is reported and data is present, stepping stops and the code stays put. When data goes away, the sequencer freezes its code and direction. When data returns, acquisition therefore resumes from the setting that held at the moment the data was lost.

Top module: `acq_sweep_seq`

## Requirements
- R1: While reset is asserted, `freq_code` is `-LIMIT` and `sweep_up` is 1.
- R2: In the rising phase (`sweep_up` = 1), each active tick adds `STEP` to the code. When the code is already at or above `LIMIT-STEP`, the tick sets it to exactly `LIMIT` and clears `sweep_up`.
- R3: In the falling phase (`sweep_up` = 0), each active tick subtracts `STEP`. When the code is already at or below `-LIMIT+STEP`, the tick sets it to exactly `-LIMIT` and sets `sweep_up` to 1. The next active tick leaves the code at `-LIMIT` (the settling tick), and the tick after it starts rising again.
- R4: Counted from the bottom of the window, one full cycle takes 2*ceil(2*LIMIT/STEP)+1 active ticks. After that many ticks the code is back at `-LIMIT` with `sweep_up` = 1.
- R5: `freq_code` and `sweep_up` change only on a clock edge where `sys_tick` is 1.
- R6: A tick seen while lock and data are both present changes neither the code nor the direction.
- R7: A tick seen while data is absent changes neither the code nor the direction, whatever the lock input says.
- R8: When lock drops or data returns, stepping resumes from the held code in the held direction.
- R9: `freq_code` always stays within `-LIMIT` to `+LIMIT`.
- R10: `lock_det` and `data_seen` take effect only after `SYNC_STAGES` clock edges. A tick on the first edge after an input change still acts on the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_tick | input | 1 | One-cycle step enable from the slow system timer |
| lock_det | input | 1 | Phase-lock indication, asynchronous |
| data_seen | input | 1 | Input-data-present flag, asynchronous |
| freq_code | output | CODE_W | Signed frequency-control code, 0 = centre |
| sweep_up | output | 1 | 1 in the rising and settling phases, 0 while falling |

## Verification
The situation hardest to reach from the ports is a tick landing in the same clock as a change on lock or data, while the synchronizer still holds the old value. The stimulus reaches it by raising `lock_det` on the same falling clock edge that raises `sys_tick`. It then expects one more step before the hold takes effect. A second hard case is a freeze that has to happen in the falling phase and in the settling tick. The stimulus reaches this by first counting ticks into the middle of the fall and to the bottom of the window, and only then removing data.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [1:0] {
    PH_RISE   = 2'd0,
    PH_FALL   = 2'd1,
    PH_SETTLE = 2'd2
  } acq_phase_e;
endpackage

// File: rtl/acq_sync.sv
module acq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d_i;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/acq_step_calc.sv
module acq_step_calc
  import acq_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int LIMIT  = 100,
  parameter int STEP   = 4
) (
  input  logic signed [CODE_W-1:0] code_i,
  input  acq_phase_e               phase_i,
  input  logic                     adv_i,
  output logic signed [CODE_W-1:0] code_o,
  output acq_phase_e               phase_o
);
  localparam int EW = CODE_W + 1;
  localparam logic signed [EW-1:0]     HI_TURN = EW'(LIMIT - STEP);
  localparam logic signed [EW-1:0]     LO_TURN = EW'(STEP - LIMIT);
  localparam logic signed [CODE_W-1:0] CMAX    = CODE_W'(LIMIT);
  localparam logic signed [CODE_W-1:0] CMIN    = CODE_W'(-LIMIT);
  localparam logic signed [CODE_W-1:0] CSTEP   = CODE_W'(STEP);

  logic signed [EW-1:0] code_x;
  assign code_x = {code_i[CODE_W-1], code_i};

  always_comb begin
    code_o  = code_i;
    phase_o = phase_i;
    if (adv_i) begin
      unique case (phase_i)
        PH_RISE: begin
          if (code_x >= HI_TURN) begin
            code_o  = CMAX;
            phase_o = PH_FALL;
          end else begin
            code_o = code_i + CSTEP;
          end
        end
        PH_FALL: begin
          if (code_x <= LO_TURN) begin
            code_o  = CMIN;
            phase_o = PH_SETTLE;
          end else begin
            code_o = code_i - CSTEP;
          end
        end
        PH_SETTLE: begin
          code_o  = CMIN;
          phase_o = PH_RISE;
        end
        default: phase_o = PH_RISE;
      endcase
    end
  end
endmodule

// File: rtl/acq_state_reg.sv
module acq_state_reg
  import acq_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int LIMIT  = 100
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en_i,
  input  logic signed [CODE_W-1:0] code_d,
  input  acq_phase_e               phase_d,
  output logic signed [CODE_W-1:0] code_q,
  output acq_phase_e               phase_q
);
  localparam logic signed [CODE_W-1:0] CMIN = CODE_W'(-LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= CMIN;
      phase_q <= PH_RISE;
    end else if (en_i) begin
      code_q  <= code_d;
      phase_q <= phase_d;
    end
  end

  // R3: the settling phase always sits at the bottom of the window
  p_settle_bottom_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SETTLE) |-> (code_q == CMIN));
endmodule

// File: rtl/acq_sweep_seq.sv
module acq_sweep_seq
  import acq_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int LIMIT       = 100,
  parameter int STEP        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sys_tick,
  input  logic                     lock_det,
  input  logic                     data_seen,
  output logic signed [CODE_W-1:0] freq_code,
  output logic                     sweep_up
);
  localparam logic signed [CODE_W-1:0] CMAX  = CODE_W'(LIMIT);
  localparam logic signed [CODE_W-1:0] CMIN  = CODE_W'(-LIMIT);
  localparam logic signed [CODE_W-1:0] CSTEP = CODE_W'(STEP);
  localparam logic signed [CODE_W:0]   HI_TURN = (CODE_W+1)'(LIMIT - STEP);

  logic lock_s, data_s, advance;
  logic signed [CODE_W-1:0] code_q, code_d;
  acq_phase_e phase_q, phase_d;

  acq_sync #(.STAGES(SYNC_STAGES)) u_sync_lock (
    .clk(clk), .rst_n(rst_n), .d_i(lock_det), .q_o(lock_s));
  acq_sync #(.STAGES(SYNC_STAGES)) u_sync_data (
    .clk(clk), .rst_n(rst_n), .d_i(data_seen), .q_o(data_s));

  assign advance = data_s & ~lock_s;

  acq_step_calc #(.CODE_W(CODE_W), .LIMIT(LIMIT), .STEP(STEP)) u_calc (
    .code_i(code_q), .phase_i(phase_q), .adv_i(advance),
    .code_o(code_d), .phase_o(phase_d));

  acq_state_reg #(.CODE_W(CODE_W), .LIMIT(LIMIT)) u_reg (
    .clk(clk), .rst_n(rst_n), .en_i(sys_tick),
    .code_d(code_d), .phase_d(phase_d),
    .code_q(code_q), .phase_q(phase_q));

  assign freq_code = code_q;
  assign sweep_up  = (phase_q != PH_FALL);

  // R9: code never leaves the window
  p_in_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_code >= CMIN) && (freq_code <= CMAX));

  // R5: nothing moves without a tick
  p_hold_no_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_tick |=> ($stable(freq_code) && $stable(sweep_up)));

  // R6: a locked tick with data present holds the code
  p_lock_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_tick && lock_s && data_s) |=> ($stable(freq_code) && $stable(sweep_up)));

  // R7: a tick without data holds the code
  p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_tick && !data_s) |=> ($stable(freq_code) && $stable(sweep_up)));

  // R2: an active rising tick below the turn point adds one step
  p_rise_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_tick && advance && phase_q == PH_RISE &&
     {freq_code[CODE_W-1], freq_code} < HI_TURN)
    |=> (freq_code == $past(freq_code) + CSTEP));
endmodule

// File: tb/acq_sweep_seq_test.sv
module acq_sweep_seq_test;
  localparam int CODE_W = 8;
  localparam int LIMIT  = 100;
  localparam int STEP   = 4;
  localparam int NHALF  = (2 * LIMIT + STEP - 1) / STEP;
  localparam int NCYC   = 2 * NHALF + 1;

  logic clk = 1'b0;
  logic rst_n, sys_tick, lock_det, data_seen;
  logic signed [CODE_W-1:0] freq_code;
  logic sweep_up;

  always #2 clk = ~clk;

  acq_sweep_seq #(.CODE_W(CODE_W), .LIMIT(LIMIT), .STEP(STEP), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .sys_tick(sys_tick), .lock_det(lock_det),
    .data_seen(data_seen), .freq_code(freq_code), .sweep_up(sweep_up));

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // behavioural model: phase 0 rising, 1 falling, 2 settling
  int m_code, m_ph;
  bit m_lock, m_data;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_code = -LIMIT;
    m_ph   = 0;
  endtask

  task automatic model_step();
    if (m_data && !m_lock) begin
      case (m_ph)
        0: if (m_code + STEP >= LIMIT) begin m_code = LIMIT; m_ph = 1; end
           else m_code = m_code + STEP;
        1: if (m_code - STEP <= -LIMIT) begin m_code = -LIMIT; m_ph = 2; end
           else m_code = m_code - STEP;
        default: begin m_code = -LIMIT; m_ph = 0; end
      endcase
    end
  endtask

  task automatic compare(input string tag);
    chk(int'(freq_code) == m_code, tag, int'(freq_code), m_code);
    chk(sweep_up == (m_ph != 1), tag, int'(sweep_up), int'(m_ph != 1));
    chk(int'(freq_code) >= -LIMIT && int'(freq_code) <= LIMIT, "R9 window",
        int'(freq_code), LIMIT);
  endtask

  // called at a falling edge; drives tick, lets one rising edge pass, compares
  task automatic cyc(input bit t, input string tag);
    sys_tick = t;
    @(posedge clk);
    if (t) model_step();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      cyc(1'b1, tag);
      for (int j = 0; j < 4; j++) cyc(1'b0, "R5 no tick");
    end
  endtask

  task automatic set_in(input bit lk, input bit dt);
    lock_det  = lk;
    data_seen = dt;
    for (int j = 0; j < 4; j++) cyc(1'b0, "R5 no tick");
    m_lock = lk;
    m_data = dt;
  endtask

  initial begin
    int hold_code;
    bit hold_dir;
    rst_n = 1'b0; sys_tick = 1'b0; lock_det = 1'b0; data_seen = 1'b0;
    m_lock = 0; m_data = 0;
    model_reset();
    repeat (3) @(negedge clk);
    compare("R1 reset");
    sys_tick = 1'b1;
    @(negedge clk);
    compare("R1 reset with tick");
    sys_tick = 1'b0;
    rst_n = 1'b1;
    set_in(1'b0, 1'b1);

    // rise to the top of the window
    ticks(NHALF, "R2 rise");
    chk(int'(freq_code) == LIMIT && !sweep_up, "R2 top turn", int'(freq_code), LIMIT);
    ticks(NHALF, "R3 fall");
    chk(int'(freq_code) == -LIMIT && sweep_up, "R3 bottom", int'(freq_code), -LIMIT);
    ticks(1, "R3 settle");
    chk(int'(freq_code) == -LIMIT && sweep_up, "R4 full cycle", int'(freq_code), -LIMIT);
    ticks(1, "R3 restart");
    chk(int'(freq_code) == -LIMIT + STEP, "R3 restart rise", int'(freq_code), -LIMIT + STEP);

    // second full cycle, counted from the bottom
    ticks(NCYC - 1, "R4 cycle");
    chk(int'(freq_code) == -LIMIT && sweep_up, "R4 second cycle", int'(freq_code), -LIMIT);

    // lock holds, release resumes
    ticks(10, "R2 rise");
    hold_code = int'(freq_code);
    set_in(1'b1, 1'b1);
    ticks(6, "R6 lock hold");
    chk(int'(freq_code) == hold_code, "R6 lock hold", int'(freq_code), hold_code);
    set_in(1'b0, 1'b1);
    ticks(1, "R8 resume");
    chk(int'(freq_code) == hold_code + STEP, "R8 resume after lock",
        int'(freq_code), hold_code + STEP);

    // data loss in the falling phase, with lock low and then high
    ticks(NHALF, "R3 fall");
    hold_code = int'(freq_code);
    hold_dir  = sweep_up;
    set_in(1'b0, 1'b0);
    ticks(5, "R7 data hold");
    set_in(1'b1, 1'b0);
    ticks(3, "R7 data hold");
    chk(int'(freq_code) == hold_code && sweep_up == hold_dir, "R7 frozen",
        int'(freq_code), hold_code);
    set_in(1'b0, 1'b1);
    ticks(1, "R8 resume");
    chk(int'(freq_code) == hold_code - STEP && !sweep_up, "R8 resume after data",
        int'(freq_code), hold_code - STEP);

    // freeze during the settling tick
    while (!(m_ph == 2)) ticks(1, "R3 fall");
    set_in(1'b0, 1'b0);
    ticks(3, "R7 settle hold");
    set_in(1'b0, 1'b1);
    ticks(1, "R3 settle resume");
    ticks(1, "R3 settle resume");
    chk(int'(freq_code) == -LIMIT + STEP, "R8 settle resume", int'(freq_code), -LIMIT + STEP);

    // same-edge input change acts on the old synchronized value
    hold_code = int'(freq_code);
    lock_det = 1'b1;
    cyc(1'b1, "R10 same edge");
    chk(int'(freq_code) == hold_code + STEP, "R10 old value used",
        int'(freq_code), hold_code + STEP);
    for (int j = 0; j < 4; j++) cyc(1'b0, "R5 no tick");
    m_lock = 1'b1;
    ticks(2, "R10 lock applied");
    chk(int'(freq_code) == hold_code + STEP, "R10 lock applied",
        int'(freq_code), hold_code + STEP);

    // asynchronous reset mid-run
    set_in(1'b0, 1'b1);
    ticks(3, "R2 rise");
    rst_n = 1'b0;
    model_reset();
    #1;
    compare("R1 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    compare("R1 after reset");

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule